// File: doc/BRIEF.md
# Dual-Slot Snapshot Capture Sequencer

This block is the global timing controller for a snapshot image array in which every pixel has two analog storage slots. It drives the array-wide controls: hold in reset, integrate, write into slot 0 or slot 1, amplify, and read from slot 0 or slot 1. Every pixel receives the same control at the same moment, so the whole frame is exposed at once. A frame always moves through reset, integration, storage, amplification and readout, in that order.

In normal mode the two slots form a ping-pong pair. A new frame is written into one slot while the frame held in the other slot is still being read out. This overlap can double the frame rate without shortening the exposure. The first slot used after reset is selectable, and the slots then alternate. A per-slot ready flag tells the readout side which slot holds a finished frame. The readout side answers with a one-cycle done pulse, which releases the slot.

In double-sampling mode one frame uses both slots. Slot 0 takes a sample just after the array leaves reset, and slot 1 takes a sample at the end of integration. Downstream logic subtracts the two samples.

Top module: `snap_seq`

## Requirements
- R1: While reset is held and afterwards until a start, `pix_reset_o` is 1 and `integ_o`, `store_o`, `amp_o`, `read_o` and `frame_rdy_o` are all 0.
- R2: A normal-mode start taken in reset produces a fixed frame sequence: `integ_o` is high for max(1, `integ_len_i`) cycles. Then, if the target slot is free, there is exactly one cycle with no control high. Then `store_o` is high on the target slot for max(1, `store_len_i`) cycles. Then `amp_o` is high for one cycle, and after that `pix_reset_o` returns.
- R3: Successive normal-mode frames alternate between slot 0 and slot 1 (`store_o` bit 0 or bit 1, reported on `cap_slot_o`).
- R4: The first normal-mode frame after reset goes into the slot given by `first_slot_i`. Later values of `first_slot_i` do not change the alternation.
- R5: `frame_rdy_o[i]` rises in the cycle after the amplification pulse of a frame stored in slot i. It falls after a `rd_done_i` pulse given while slot i is being read.
- R6: `read_o` is one-hot on the oldest ready slot and is 0 when no slot is ready. A `rd_done_i` pulse while nothing is ready is ignored.
- R7: A frame whose target slot is still ready (unread) waits after integration, with no control high, until that slot is released. Only then does it store.
- R8: `store_o` is never high on more than one slot, and never on the slot that `read_o` selects in the same cycle.
- R9: A double-sampling frame stores slot 0 for max(1, `store_len_i`) cycles with `integ_o` high. Then it integrates for max(1, `integ_len_i`) cycles, stores slot 1 for max(1, `store_len_i`) cycles, and amplifies. Both ready flags then rise, and readout takes slot 0 first, then slot 1. The next normal frame targets slot 0.
- R10: A double-sampling start keeps the array in reset until both slots are released.
- R11: `start_i` is ignored while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one frame (taken only while in reset phase) |
| cds_mode_i | input | 1 | 1 = double-sampling frame, 0 = normal ping-pong frame |
| first_slot_i | input | 1 | Slot for the first normal frame after reset |
| integ_len_i | input | IW | Integration length in cycles (0 acts as 1) |
| store_len_i | input | SW | Store strobe length in cycles (0 acts as 1) |
| rd_done_i | input | 1 | Readout of the selected slot finished |
| pix_reset_o | output | 1 | Array held in reset |
| integ_o | output | 1 | Array integrating |
| store_o | output | 2 | Store-into-slot strobes |
| amp_o | output | 1 | Amplification strobe |
| read_o | output | 2 | Read-from-slot selects |
| frame_rdy_o | output | 2 | Per-slot finished-frame flags |
| cap_slot_o | output | 1 | Slot the current capture targets |
| rd_slot_o | output | 1 | Slot the readout side is served next |

## Verification
The hardest situation to reach is a capture that has finished integrating while its target slot is still unread. The stimulus sets this up by storing two frames with no readout between them. It then starts a third frame and watches for 30 cycles that no store strobe appears. It then releases the older slot and checks that the store follows on that slot. The double-sampling stall is reached the same way: one normal frame is left unread, and then a double-sampling start is issued. Sweeps over small integration and store lengths, including 0, check every phase duration arithmetically.

// File: rtl/snap_pkg.sv
// Shared types for the snapshot capture sequencer.
package snap_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,   // array held in reset, waiting for start
        PH_CWAIT,  // double-sampling start, waiting for both slots free
        PH_PRE,    // double-sampling reset sample into slot 0
        PH_INTEG,  // integrating
        PH_HOLD,   // integration complete, waiting for target slot
        PH_STORE,  // store strobe on target slot
        PH_AMP     // amplification pulse
    } phase_t;
endpackage

// File: rtl/snap_phase_ctrl.sv
// Phase controller: steps one frame through reset, integration, storage
// and amplification; counts integration and store lengths; picks the
// target slot. Assumes the mode changes only while no frame is pending.
module snap_phase_ctrl
    import snap_pkg::*;
#(
    parameter int IW = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cds_i,
    input  logic          first_slot_i,
    input  logic [IW-1:0] integ_len_i,
    input  logic [SW-1:0] store_len_i,
    input  logic [1:0]    frame_rdy_i,
    output phase_t        phase_o,
    output logic          slot_o,
    output logic          cds_o,
    output logic          done_o
);
    localparam int CW = (IW > SW) ? IW : SW;

    phase_t        ph;
    logic [CW-1:0] cnt;
    logic          slot;
    logic          cds_q;
    logic          cap_ptr;
    logic          fresh;
    logic [CW-1:0] ilen_m1;
    logic [CW-1:0] slen_m1;

    // Lengths minus one, with zero treated as one cycle.
    always_comb begin
        ilen_m1 = (integ_len_i == '0) ? '0 : CW'(integ_len_i) - CW'(1);
        slen_m1 = (store_len_i == '0) ? '0 : CW'(store_len_i) - CW'(1);
    end

    // Phase sequencing, length counting and slot choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            slot    <= 1'b0;
            cds_q   <= 1'b0;
            cap_ptr <= 1'b0;
            fresh   <= 1'b1;
        end else begin
            case (ph)
                PH_IDLE: if (start_i) begin
                    cds_q <= cds_i;
                    if (cds_i) begin
                        ph <= PH_CWAIT;
                    end else begin
                        ph   <= PH_INTEG;
                        cnt  <= ilen_m1;
                        slot <= fresh ? first_slot_i : cap_ptr;
                    end
                end
                PH_CWAIT: if (frame_rdy_i == 2'b00) begin
                    ph   <= PH_PRE;
                    cnt  <= slen_m1;
                    slot <= 1'b0;
                end
                PH_PRE: if (cnt == '0) begin
                    ph  <= PH_INTEG;
                    cnt <= ilen_m1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
                PH_INTEG: if (cnt == '0) begin
                    ph <= PH_HOLD;
                    if (cds_q) slot <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
                PH_HOLD: if (!frame_rdy_i[slot]) begin
                    ph  <= PH_STORE;
                    cnt <= slen_m1;
                end
                PH_STORE: if (cnt == '0) begin
                    ph <= PH_AMP;
                end else begin
                    cnt <= cnt - CW'(1);
                end
                PH_AMP: begin
                    ph      <= PH_IDLE;
                    fresh   <= 1'b0;
                    cap_ptr <= cds_q ? 1'b0 : ~slot;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = ph;
    assign slot_o  = slot;
    assign cds_o   = cds_q;
    assign done_o  = (ph == PH_AMP);
endmodule

// File: rtl/snap_slot_track.sv
// Slot tracker: keeps one ready flag per slot and a read pointer to the
// oldest ready slot; serves readout and releases slots on done pulses.
// Assumes a frame is only stored into a slot whose flag is clear.
module snap_slot_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       cds_i,
    input  logic       slot_i,
    input  logic       rd_done_i,
    output logic [1:0] frame_rdy_o,
    output logic [1:0] read_o,
    output logic       rd_slot_o
);
    logic [1:0] rdy;
    logic       rd_ptr;
    logic [1:0] clr;
    logic [1:0] set_mask;
    logic [1:0] kept;

    // Release and set masks for this cycle.
    always_comb begin
        clr      = (rd_done_i && rdy[rd_ptr]) ? (2'b01 << rd_ptr) : 2'b00;
        set_mask = !set_i ? 2'b00 : (cds_i ? 2'b11 : (2'b01 << slot_i));
        kept     = rdy & ~clr;
    end

    // Ready flags and oldest-first read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy    <= 2'b00;
            rd_ptr <= 1'b0;
        end else begin
            rdy <= kept | set_mask;
            if (set_i && kept == 2'b00) begin
                rd_ptr <= cds_i ? 1'b0 : slot_i;
            end else if (clr != 2'b00) begin
                rd_ptr <= ~rd_ptr;
            end
        end
    end

    assign frame_rdy_o = rdy;
    assign read_o      = rdy[rd_ptr] ? (2'b01 << rd_ptr) : 2'b00;
    assign rd_slot_o   = rd_ptr;
endmodule

// File: rtl/snap_strobe_dec.sv
// Strobe decoder: turns the current phase and target slot into the
// array-wide control lines. Purely combinational.
module snap_strobe_dec
    import snap_pkg::*;
#(
    parameter int NSLOT = 2
) (
    input  phase_t           phase_i,
    input  logic             slot_i,
    output logic             pix_reset_o,
    output logic             integ_o,
    output logic             amp_o,
    output logic [NSLOT-1:0] store_o
);
    // Phase-wide controls.
    always_comb begin
        pix_reset_o = (phase_i == PH_IDLE) || (phase_i == PH_CWAIT);
        integ_o     = (phase_i == PH_PRE) || (phase_i == PH_INTEG);
        amp_o       = (phase_i == PH_AMP);
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_store
        // Store line for slot g: target slot in store phase, slot 0 in pre-sample.
        assign store_o[g] = ((phase_i == PH_STORE) && (int'(slot_i) == g))
                         || ((phase_i == PH_PRE) && (g == 0));
    end
endmodule

// File: rtl/snap_seq.sv
// Top of the dual-slot snapshot capture sequencer: phase controller,
// slot tracker and strobe decoder. All outputs act array-wide.
module snap_seq
    import snap_pkg::*;
#(
    parameter int IW = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cds_mode_i,
    input  logic          first_slot_i,
    input  logic [IW-1:0] integ_len_i,
    input  logic [SW-1:0] store_len_i,
    input  logic          rd_done_i,
    output logic          pix_reset_o,
    output logic          integ_o,
    output logic [1:0]    store_o,
    output logic          amp_o,
    output logic [1:0]    read_o,
    output logic [1:0]    frame_rdy_o,
    output logic          cap_slot_o,
    output logic          rd_slot_o
);
    phase_t phase;
    logic   slot;
    logic   cds_q;
    logic   done;

    snap_phase_ctrl #(.IW(IW), .SW(SW)) u_phase (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cds_i(cds_mode_i),
        .first_slot_i(first_slot_i), .integ_len_i(integ_len_i),
        .store_len_i(store_len_i), .frame_rdy_i(frame_rdy_o),
        .phase_o(phase), .slot_o(slot), .cds_o(cds_q), .done_o(done)
    );

    snap_slot_track u_track (
        .clk(clk), .rst_n(rst_n), .set_i(done), .cds_i(cds_q),
        .slot_i(slot), .rd_done_i(rd_done_i), .frame_rdy_o(frame_rdy_o),
        .read_o(read_o), .rd_slot_o(rd_slot_o)
    );

    snap_strobe_dec #(.NSLOT(2)) u_dec (
        .phase_i(phase), .slot_i(slot), .pix_reset_o(pix_reset_o),
        .integ_o(integ_o), .amp_o(amp_o), .store_o(store_o)
    );

    assign cap_slot_o = slot;
endmodule

// File: rtl/snap_seq_chk.sv
// Checker for snap_seq: port-level protocol properties.
module snap_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_done_i,
    input logic       pix_reset_o,
    input logic       integ_o,
    input logic [1:0] store_o,
    input logic       amp_o,
    input logic [1:0] read_o,
    input logic [1:0] frame_rdy_o
);
    // R8
    store_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_o & read_o) == 2'b00);
    // R8
    store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(store_o));
    // R2
    reset_integ_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_reset_o && integ_o));
    // R2
    amp_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_o) |-> $past(store_o != 2'b00));
    // R5
    rdy0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_rdy_o[0]) |-> $past(amp_o));
    // R5
    rdy1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_rdy_o[1]) |-> $past(amp_o));
    // R5
    rdy1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && read_o[1]) |=> !frame_rdy_o[1]);
    // R6
    read_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read_o & ~frame_rdy_o) == 2'b00);
    // R7
    store_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_o[0]) |-> !frame_rdy_o[0]);
endmodule

bind snap_seq snap_seq_chk u_chk (.*);

// File: tb/snap_seq_bench.sv
module snap_seq_bench;
    localparam int IW = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cds_mode_i = 1'b0;
    logic          first_slot_i = 1'b0;
    logic [IW-1:0] integ_len_i = '0;
    logic [SW-1:0] store_len_i = '0;
    logic          rd_done_i = 1'b0;
    logic          pix_reset_o, integ_o, amp_o, cap_slot_o, rd_slot_o;
    logic [1:0]    store_o, read_o, frame_rdy_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_excl = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    snap_seq #(.IW(IW), .SW(SW)) u_snap_seq (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // R8: store never on the slot being read
    always @(negedge clk) if (rst_n && (store_o & read_o) != 2'b00) n_excl++;

    task automatic do_reset(input bit first);
        rst_n = 1'b0;
        first_slot_i = first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Runs one normal frame and checks its phase durations and slot.
    task automatic capture(input int n, input int l, input bit exp_slot, input bit spam);
        int ni = 0, ns = 0, nh = 0, na = 0, nbad = 0, guard = 0;
        bit seen_store = 0;
        cds_mode_i = 1'b0;
        integ_len_i = IW'(n);
        store_len_i = SW'(l);
        start_i = 1'b1;
        @(negedge clk);
        if (!spam) start_i = 1'b0;
        while (!pix_reset_o && guard < 5000) begin
            if (integ_o && store_o == 2'b00) ni++;
            else if (store_o == (2'b01 << exp_slot)) begin ns++; seen_store = 1; end
            else if (store_o != 2'b00) nbad++;
            else if (amp_o) na++;
            else nh++;
            if (seen_store) start_i = 1'b0;
            guard++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R2 integ cycles", ni, atleast1(n));
        chk("R2 store cycles", ns, atleast1(l));
        chk("R2 hold cycles", nh, 1);
        chk("R2 amp cycles", na, 1);
        chk("R3 wrong-slot store cycles", nbad, 0);
        chk("R5 ready after amp", int'(frame_rdy_o[exp_slot]), 1);
    endtask

    // Reads out one slot through the handshake.
    task automatic read_one(input bit exp_slot);
        chk("R6 read select", int'(read_o), int'(2'b01 << exp_slot));
        chk("R6 read pointer", int'(rd_slot_o), int'(exp_slot));
        rd_done_i = 1'b1;
        @(negedge clk);
        rd_done_i = 1'b0;
        chk("R5 ready released", int'(frame_rdy_o[exp_slot]), 0);
    endtask

    // Monitors a double-sampling frame (start already issued if !do_start).
    task automatic cds_frame(input int n, input int l, input bit do_start);
        int c_pre = 0, c_int = 0, c_s1 = 0, na = 0, guard = 0;
        bit active = 0;
        cds_mode_i = 1'b1;
        integ_len_i = IW'(n);
        store_len_i = SW'(l);
        if (do_start) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!(active && pix_reset_o) && guard < 5000) begin
            if (!pix_reset_o) active = 1;
            if (store_o == 2'b01 && integ_o) c_pre++;
            else if (integ_o && store_o == 2'b00) c_int++;
            else if (store_o == 2'b10 && !integ_o) c_s1++;
            else if (amp_o) na++;
            guard++;
            @(negedge clk);
        end
        cds_mode_i = 1'b0;
        chk("R9 reset sample cycles", c_pre, atleast1(l));
        chk("R9 integ cycles", c_int, atleast1(n));
        chk("R9 signal sample cycles", c_s1, atleast1(l));
        chk("R9 amp cycles", na, 1);
        chk("R9 both ready", int'(frame_rdy_o), 3);
    endtask

    initial begin
        bit e;
        int stall_store;
        do_reset(1'b1);
        // R1 reset state
        chk("R1 pix_reset", int'(pix_reset_o), 1);
        chk("R1 integ", int'(integ_o), 0);
        chk("R1 store", int'(store_o), 0);
        chk("R1 amp", int'(amp_o), 0);
        chk("R1 read", int'(read_o), 0);
        chk("R1 frame_rdy", int'(frame_rdy_o), 0);

        // R2 R3 R4 sweep: first slot 1, alternation unaffected by first_slot_i
        e = 1'b1;
        for (int n = 0; n < 4; n++) begin
            for (int l = 0; l < 3; l++) begin
                if (n + l > 0) first_slot_i = n[0];
                capture(n, l, e, 1'b0);
                read_one(e);
                e = ~e;
            end
        end

        // R6: done pulse with nothing ready is ignored
        rd_done_i = 1'b1;
        repeat (3) @(negedge clk);
        rd_done_i = 1'b0;
        chk("R6 ignored done rdy", int'(frame_rdy_o), 0);
        chk("R6 ignored done read", int'(read_o), 0);

        // R3 R6 ping-pong, oldest read first
        capture(5, 2, e, 1'b0);
        capture(3, 1, ~e, 1'b0);
        chk("R3 both slots ready", int'(frame_rdy_o), 3);
        read_one(e);
        read_one(~e);

        // R7 stall while target slot unread
        capture(2, 1, e, 1'b0);
        capture(2, 1, ~e, 1'b0);
        integ_len_i = IW'(2);
        store_len_i = SW'(1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stall_store = 0;
        for (int k = 0; k < 30; k++) begin
            if (store_o != 2'b00) stall_store++;
            @(negedge clk);
        end
        chk("R7 no store while slot busy", stall_store, 0);
        chk("R7 array not in reset during stall", int'(pix_reset_o), 0);
        read_one(e);
        stall_store = 0;
        for (int k = 0; k < 10; k++) begin
            if (store_o == (2'b01 << e)) stall_store++;
            @(negedge clk);
        end
        chk("R7 store after release", stall_store, 1);
        chk("R7 slot refilled", int'(frame_rdy_o), 3);
        read_one(~e);
        read_one(e);
        e = ~e;

        // R11 start held during a frame is ignored
        capture(3, 2, e, 1'b1);
        repeat (5) @(negedge clk);
        chk("R11 no extra frame", int'(pix_reset_o), 1);
        read_one(e);
        e = ~e;

        // R4 after a fresh reset, first_slot_i = 0
        do_reset(1'b0);
        capture(1, 1, 1'b0, 1'b0);
        read_one(1'b0);

        // R9 double-sampling frame and readout order
        cds_frame(4, 2, 1'b1);
        read_one(1'b0);
        read_one(1'b1);
        capture(1, 1, 1'b0, 1'b0);   // R9: next normal frame targets slot 0

        // R10 double-sampling start waits in reset for both slots
        cds_mode_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stall_store = 0;
        for (int k = 0; k < 10; k++) begin
            if (!pix_reset_o) stall_store++;
            @(negedge clk);
        end
        chk("R10 held in reset", stall_store, 0);
        read_one(1'b0);
        cds_frame(1, 0, 1'b0);
        read_one(1'b0);
        read_one(1'b1);

        chk("R8 store/read overlap cycles", n_excl, 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule